// File: doc/BRIEF.md
# Soft-Decision Product Parity Decoding Engine

This block performs the inner work of an iterative soft-in soft-out decoder for a multi-dimensional product of single-parity-check codes. The code word holds N^D bits arranged as a D-dimensional cube with N bits per side. Each parity line runs along one axis and contains N bits. For every bit, the block keeps one signed extrinsic value per dimension. It also takes a per-bit channel log-likelihood value and a per-bit external extrinsic value supplied by a companion decoder.

A run starts with a single `start` strobe. The strobe clears every stored extrinsic and loads the number of decoding cycles requested. On each following clock, the engine updates one dimension for the whole cube. It visits the dimensions in the order 0, 1, … D-1 and then wraps back to 0.

During a cycle on dimension q, each bit first receives a combined value. This value is the channel value plus the external term plus the stored extrinsics of every dimension other than q. The new extrinsic for dimension q is then found with the min-sum rule applied to the combined values of the other bits on the bit's line.

The soft output of every bit is the channel value plus the external term plus all D stored extrinsics. The hard decision is taken from the sign of that output. All arithmetic is 8-bit two's complement and saturates to a symmetric range. When the last requested cycle has been written, a one-clock `done` pulse appears, and the outputs are valid from then on.

Top module: `spc_prod_cycle`

## Requirements
- R1: After reset, `busy` and `done` are 0, every stored extrinsic is zero, and each `out_llr` element equals sat(channel + external).
- R2: A `start` pulse while idle clears every stored extrinsic. A `start` while `busy` is 1 is ignored: the run continues unchanged, and its length and results are not affected.
- R3: Every sum saturates to the range -127..+127. The code 0x80 (-128) never appears in a stored extrinsic or in `out_llr`.
- R4: In a cycle on dimension q, the combined value of bit k is sat(ch[k] + ext_in[k] + Σ over i≠q of E_i[k]). The sum is formed at full precision and then saturated once.
- R5: The magnitude of the new E_q[k] is the smallest |combined value| among the other N-1 bits on bit k's line along q.
- R6: The new E_q[k] is negative exactly when an odd number of the other bits on the line have a negative combined value. Zero counts as positive.
- R7: While `busy` is 1, one dimension is updated per clock. `cur_dim` shows the dimension that the next clock updates: it is 0 after start and steps 0,1,…,D-1,0,…
- R8: `busy` stays 1 for exactly `num_cycles` clocks, and `done` pulses for one clock as `busy` falls. With `num_cycles` = 0, `busy` stays 0 and `done` pulses on the clock after start.
- R9: `out_llr[k]` = sat(ch[k] + ext_in[k] + Σ over all i of E_i[k]). `hard[k]` is 1 when `out_llr[k]` is negative, and 0 when it is zero or positive.
- R10: Bit k sits at element k of each flat vector, with bits [8k+7:8k]. Its coordinate along dimension q is (k / N^q) mod N. A line along q is the set of N bits that share all their other coordinates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run (used only while idle) |
| num_cycles | input | CW | Number of decoding cycles in the run |
| ch_llr | input | NB*W | Channel values, one per bit |
| ext_in | input | NB*W | External extrinsic values, one per bit |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-clock pulse when the run ends |
| cur_dim | output | DW | Dimension updated on the next clock |
| out_llr | output | NB*W | Soft output per bit |
| hard | output | NB | Hard decision per bit |

## Verification
The assertions assume three things about the inputs. First, `ch_llr` and `ext_in` stay constant from the start strobe until `done`. Second, reset is applied before the first run. Third, the hold check on the stored extrinsics relies on `start` being the only way an idle engine changes state. The bench changes channel and external values only on falling edges between runs, never while `busy` is 1. Its single deliberate violation is a second `start` strobe during a run, which exercises the ignore rule.

// File: rtl/spc_prod_cycle.sv
module spc_prod_cycle #(
  parameter int N  = 4,
  parameter int D  = 2,
  parameter int W  = 8,
  parameter int CW = 8,
  localparam int NB = N ** D,
  localparam int DW = (D > 1) ? $clog2(D) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [CW-1:0]   num_cycles,
  input  logic [NB*W-1:0] ch_llr,
  input  logic [NB*W-1:0] ext_in,
  output logic            busy,
  output logic            done,
  output logic [DW-1:0]   cur_dim,
  output logic [NB*W-1:0] out_llr,
  output logic [NB-1:0]   hard
);
  localparam int MAXV = 2 ** (W - 1) - 1;
  localparam int AW   = $clog2(NB);

  logic [D*NB*W-1:0] ext_q;
  logic [NB*W-1:0]   new_ext;
  logic [W-1:0]      cmb [NB];
  logic [CW-1:0]     cnt;

  function automatic logic [W-1:0] sat(input int v);
    if (v > MAXV) return W'(MAXV);
    if (v < -MAXV) return W'(-MAXV);
    return W'(v);
  endfunction

  function automatic int sx(input logic [W-1:0] v);
    return int'($signed(v));
  endfunction

  always_comb begin
    int stride, acc, dig, p, mn, mg;
    logic sg;
    logic [AW-1:0] pi;
    stride = 1;
    for (int i = 0; i < D; i++)
      if (i < int'(cur_dim)) stride = stride * N;
    for (int k = 0; k < NB; k++) begin
      acc = sx(ch_llr[k*W +: W]) + sx(ext_in[k*W +: W]);
      for (int i = 0; i < D; i++)
        if (i != int'(cur_dim)) acc = acc + sx(ext_q[(i*NB+k)*W +: W]);
      cmb[k] = sat(acc);
    end
    for (int k = 0; k < NB; k++) begin
      dig = (k / stride) % N;
      mn  = MAXV;
      sg  = 1'b0;
      for (int j = 0; j < N; j++) begin
        if (j != dig) begin
          p  = k + (j - dig) * stride;
          pi = AW'(p);
          mg = sx(cmb[pi]);
          if (mg < 0) mg = -mg;
          if (mg < mn) mn = mg;
          sg = sg ^ cmb[pi][W-1];
        end
      end
      new_ext[k*W +: W] = sg ? W'(-mn) : W'(mn);
    end
  end

  always_comb begin
    int acc;
    for (int k = 0; k < NB; k++) begin
      acc = sx(ch_llr[k*W +: W]) + sx(ext_in[k*W +: W]);
      for (int i = 0; i < D; i++) acc = acc + sx(ext_q[(i*NB+k)*W +: W]);
      out_llr[k*W +: W] = sat(acc);
    end
  end

  for (genvar k = 0; k < NB; k++) begin : g_hard
    assign hard[k] = out_llr[k*W + W - 1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q   <= '0;
      cnt     <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      cur_dim <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        ext_q   <= '0;
        cnt     <= num_cycles;
        cur_dim <= '0;
        busy    <= (num_cycles != '0);
        done    <= (num_cycles == '0);
      end else if (busy) begin
        for (int i = 0; i < D; i++)
          if (i == int'(cur_dim)) ext_q[i*NB*W +: NB*W] <= new_ext;
        cur_dim <= (int'(cur_dim) == D - 1) ? '0 : cur_dim + 1'b1;
        cnt     <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spc_prod_cycle_chk.sv
module spc_prod_cycle_chk #(
  parameter int N = 4,
  parameter int D = 2,
  parameter int W = 8,
  localparam int NB = N ** D,
  localparam int DW = (D > 1) ? $clog2(D) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [DW-1:0]   cur_dim,
  input logic [D*NB*W-1:0] ext_q,
  input logic [NB*W-1:0] out_llr
);
  localparam logic [W-1:0] MINCODE = {1'b1, {(W-1){1'b0}}};

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_dim_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> int'(cur_dim) == ((int'($past(cur_dim)) == D - 1) ? 0 : int'($past(cur_dim)) + 1));

  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (ext_q == '0));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(ext_q));

  for (genvar k = 0; k < NB; k++) begin : g_rng
    p_no_min_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_llr[k*W +: W] != MINCODE);
  end
  for (genvar e = 0; e < D*NB; e++) begin : g_erng
    p_no_min_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ext_q[e*W +: W] != MINCODE);
  end
endmodule

bind spc_prod_cycle spc_prod_cycle_chk #(.N(N), .D(D), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .cur_dim(cur_dim), .ext_q(ext_q), .out_llr(out_llr)
);

// File: tb/tb_spc_prod_cycle.sv
module tb_spc_prod_cycle;
  localparam int N = 4, D = 2, W = 8, CW = 8;
  localparam int NB = N ** D;
  localparam int DW = (D > 1) ? $clog2(D) : 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [CW-1:0] num_cycles = '0;
  logic [NB*W-1:0] ch_llr = '0, ext_in = '0;
  logic busy, done;
  logic [DW-1:0] cur_dim;
  logic [NB*W-1:0] out_llr;
  logic [NB-1:0] hard;

  int checks = 0, fails = 0;
  int mch[NB], mle[NB], mext[D][NB];

  always #4 clk = ~clk;

  spc_prod_cycle #(.N(N), .D(D), .W(W), .CW(CW)) dut (.*);

  function automatic int bsat(int v);
    return (v > 127) ? 127 : (v < -127) ? -127 : v;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_inputs();
    for (int k = 0; k < NB; k++) begin
      ch_llr[k*W +: W] = W'(mch[k]);
      ext_in[k*W +: W] = W'(mle[k]);
    end
  endtask

  task automatic m_clear();
    for (int i = 0; i < D; i++) for (int k = 0; k < NB; k++) mext[i][k] = 0;
  endtask

  task automatic m_step(int q);
    int c[NB], nx[NB];
    int s = N ** q;
    for (int k = 0; k < NB; k++) begin
      int a = mch[k] + mle[k];
      for (int i = 0; i < D; i++) if (i != q) a += mext[i][k];
      c[k] = bsat(a);
    end
    for (int k = 0; k < NB; k++) begin
      int base = k - ((k / s) % N) * s;
      int mn = 127, neg = 0;
      for (int j = 0; j < N; j++) begin
        int p = base + j * s;
        if (p != k) begin
          int m = (c[p] < 0) ? -c[p] : c[p];
          if (m < mn) mn = m;
          if (c[p] < 0) neg ^= 1;
        end
      end
      nx[k] = neg ? -mn : mn;
    end
    for (int k = 0; k < NB; k++) mext[q][k] = nx[k];
  endtask

  task automatic compare_out(string tag);
    int bad = -1, ea = 0, ee = 0, hb = -1;
    for (int k = 0; k < NB; k++) begin
      int e = mch[k] + mle[k];
      for (int i = 0; i < D; i++) e += mext[i][k];
      e = bsat(e);
      if (bad < 0 && int'($signed(out_llr[k*W +: W])) != e) begin
        bad = k; ea = int'($signed(out_llr[k*W +: W])); ee = e;
      end
      if (hb < 0 && hard[k] != (e < 0)) hb = k;
    end
    check(bad < 0, {tag, " out_llr R9"}, ea, ee);
    check(hb < 0, {tag, " hard R9"}, hb, -1);
  endtask

  task automatic run(int cyc, output int nbusy);
    @(negedge clk); num_cycles = CW'(cyc); start = 1'b1;
    @(negedge clk); start = 1'b0;
    nbusy = 0;
    for (int t = 0; t < 1000; t++) begin
      if (done) break;
      if (busy) nbusy++;
      @(negedge clk);
    end
    m_clear();
    for (int c = 0; c < cyc; c++) m_step(c % D);
  endtask

  task automatic t_reset();
    for (int k = 0; k < NB; k++) begin mch[k] = 100; mle[k] = (k % 2) ? 100 : -100; end
    set_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && done == 0, "R1 idle after reset", int'(busy), 0);
    m_clear();
    compare_out("R1 reset R3");
  endtask

  task automatic t_hand();
    int nb;
    for (int k = 0; k < NB; k++) begin mch[k] = 50; mle[k] = 0; end
    mch[0] = 10; mch[1] = -20; mch[2] = 30; mch[3] = 40;
    set_inputs();
    run(1, nb);
    check(int'($signed(out_llr[0 +: W])) == -10, "R5 R6 R10 bit0", int'($signed(out_llr[0 +: W])), -10);
    check(int'($signed(out_llr[W +: W])) == -10, "R5 bit1", int'($signed(out_llr[W +: W])), -10);
    check(int'($signed(out_llr[2*W +: W])) == 20, "R6 bit2", int'($signed(out_llr[2*W +: W])), 20);
    check(int'($signed(out_llr[5*W +: W])) == 100, "R5 bit5", int'($signed(out_llr[5*W +: W])), 100);
    check(hard[3:0] == 4'b0011, "R9 hard low nibble", int'(hard[3:0]), 3);
    compare_out("R10 hand");
  endtask

  task automatic t_order();
    int seq[8];
    int n = 0;
    @(negedge clk); num_cycles = CW'(5); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int t = 0; t < 20 && !done; t++) begin
      if (busy && n < 8) begin seq[n] = int'(cur_dim); n++; end
      @(negedge clk);
    end
    check(n == 5, "R8 busy length 5", n, 5);
    for (int c = 0; c < 5; c++) check(seq[c] == c % D, "R7 dim order", seq[c], c % D);
    check(done == 1, "R8 done pulse", int'(done), 1);
    @(negedge clk);
    check(done == 0, "R8 done one clock", int'(done), 0);
  endtask

  task automatic t_zero();
    int nb;
    for (int k = 0; k < NB; k++) begin mch[k] = k * 7 - 50; mle[k] = 3; end
    set_inputs();
    run(3, nb);
    run(0, nb);
    check(nb == 0, "R8 zero cycles no busy", nb, 0);
    compare_out("R2 start clears");
  endtask

  task automatic t_ignore();
    int nb = 0;
    for (int k = 0; k < NB; k++) begin mch[k] = 60 - k * 9; mle[k] = -5; end
    set_inputs();
    @(negedge clk); num_cycles = CW'(4); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (busy) nb++;
    @(negedge clk); num_cycles = CW'(9); start = 1'b1;
    if (busy) nb++;
    @(negedge clk); start = 1'b0;
    for (int t = 0; t < 50 && !done; t++) begin
      if (busy) nb++;
      @(negedge clk);
    end
    check(nb == 4, "R2 start during busy ignored", nb, 4);
    m_clear();
    for (int c = 0; c < 4; c++) m_step(c % D);
    compare_out("R2 ignore");
  endtask

  task automatic t_random();
    int nb;
    for (int r = 0; r < 12; r++) begin
      for (int k = 0; k < NB; k++) begin
        mch[k] = int'($signed(8'($urandom)));
        mle[k] = (r % 3 == 0) ? 0 : int'($signed(8'($urandom))) / ((r % 2) ? 1 : 8);
      end
      set_inputs();
      run(1 + r % 6, nb);
      check(nb == 1 + r % 6, "R8 busy length", nb, 1 + r % 6);
      compare_out("R4 R3 random");
    end
  endtask

  initial begin
    t_reset();
    t_hand();
    t_order();
    t_zero();
    t_ignore();
    t_random();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule